// File: doc/BRIEF.md
# Three-Wire Serial Configuration Write Port

This block is the receiving side of a write-only serial configuration link. A host pulls an active-low select line, then clocks out a 16-bit frame on a serial data line. On each rising edge of the serial clock the block takes one bit. The frame holds a 2-bit device code, a direction bit, a 5-bit register index and an 8-bit value, each field sent most significant bit first. When the device code is binary 01 and the direction bit is 1, the value is stored on the sixteenth rising edge into one of the addressable 8-bit configuration registers. All registers are presented in parallel on one output bus.

The three serial wires and the mode select pass through synchronizers into the system clock, and the serial clock edges are found in that domain. For this reason the system clock must run at least four times faster than the serial clock, whose top rate is 5 MHz. A low level on the power-down input returns every register to its default value. The serial port listens only while the mode select input is low. Of the 32 register indices, only the first `REG_COUNT` are implemented. Frames aimed at higher indices are received in full but change nothing.

Top module: `ctl_wr_port`

## Requirements
- R1: While `pdn_n_i` is low, register i (0 ≤ i < REG_COUNT) holds the default value `DFLT_BASE + i*DFLT_STEP` modulo 256, and it keeps that value after release until a valid write reaches it.
- R2: A frame is 16 bits, sampled on the rising edges of `sclk_i` while `csn_i` is low. The first bit is bit 15. Bits 15:14 are the device code, bit 13 is the direction bit, bits 12:8 are the register index and bits 7:0 are the data. A valid frame leaves the data in register (index) at bit position `index*8` of `regs_o`.
- R3: A frame whose device code is anything other than binary 01 changes no register.
- R4: A frame whose direction bit is 0 changes no register.
- R5: A valid write commits on the 16th rising serial edge of the frame. After 15 rising edges every register still holds its old value.
- R6: While `ps_sel_i` is high, frames are ignored and no register changes.
- R7: Raising `csn_i` before the 16th rising edge abandons the frame without any write. The next low level of `csn_i` starts a new frame from bit 15.
- R8: Rising serial edges after the 16th one, before `csn_i` goes high, neither cause another write nor alter the value just written.
- R9: A valid frame whose index is REG_COUNT or above is accepted on the wire but changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 4x the serial clock rate |
| pdn_n_i | input | 1 | Active-low power-down; asynchronously restores all register defaults |
| ps_sel_i | input | 1 | Mode select; serial port enabled when low |
| csn_i | input | 1 | Active-low frame select from the host |
| sclk_i | input | 1 | Serial clock; data sampled on its rising edge |
| sdi_i | input | 1 | Serial data, changed by the host on the falling edge |
| regs_o | output | REG_COUNT*8 | Register file contents, register i in bits i*8+7 : i*8 |

## Verification
The bench builds the block with its defaults: REG_COUNT of 24, a two-stage synchronizer, and a base of 0x10 stepped by 5 for the defaults. With these values the eight unimplemented indices 24 to 31 lie inside the 5-bit index space, so a single sweep of 256 frames covers every index, both implemented and discarded, and every data byte. The serial clock runs at one eighth of the system rate. This keeps sixteen edges short enough that every abort point from 1 to 15 bits, every rejected device code, the 15-edge hold and the trailing-edge case can each be run in turn against a model computed from the default formula.

// File: rtl/ctl_wr_pkg.sv
package ctl_wr_pkg;

    localparam int DEV_W      = 2;
    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 8;
    localparam int FRAME_BITS = DEV_W + 1 + ADDR_W + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [DEV_W-1:0] DEV_CODE = 2'b01;

    typedef logic [ADDR_W-1:0] reg_idx_t;
    typedef logic [DATA_W-1:0] reg_val_t;

    typedef struct packed {
        logic [CNT_W-1:0]      cnt;
        logic [FRAME_BITS-2:0] shreg;
        logic                  sclk_prev;
    } frame_state_t;

endpackage

// File: rtl/ctl_wr_sync.sv
module ctl_wr_sync #(
    parameter int               WIDTH   = 4,
    parameter int               STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= RST_VAL;
            end
        end else begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= stage_d[s];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/ctl_wr_frame.sv
module ctl_wr_frame
    import ctl_wr_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_n_i,
    input  logic             ps_s_i,
    input  logic             csn_s_i,
    input  logic             sclk_s_i,
    input  logic             sdi_s_i,
    output logic             commit_o,
    output reg_idx_t         wr_addr_o,
    output reg_val_t         wr_data_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             active_o
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);
    localparam logic [CNT_W-1:0] FULL     = CNT_W'(FRAME_BITS);

    frame_state_t st_d, st_q;
    logic         active;
    logic         rise;
    logic [FRAME_BITS-1:0] word;
    logic         fields_ok;

    always_comb begin
        active    = !csn_s_i && !ps_s_i;
        rise      = sclk_s_i && !st_q.sclk_prev;
        word      = {st_q.shreg, sdi_s_i};
        fields_ok = (word[FRAME_BITS-1 -: DEV_W] == DEV_CODE)
                 && word[ADDR_W + DATA_W];

        st_d           = st_q;
        st_d.sclk_prev = sclk_s_i;
        if (!active) begin
            st_d.cnt = '0;
        end else if (rise && (st_q.cnt < FULL)) begin
            st_d.shreg = {st_q.shreg[FRAME_BITS-3:0], sdi_s_i};
            st_d.cnt   = st_q.cnt + 1'b1;
        end

        commit_o  = active && rise && (st_q.cnt == LAST_BIT) && fields_ok;
        wr_addr_o = word[DATA_W +: ADDR_W];
        wr_data_o = word[DATA_W-1:0];
    end

    always_ff @(posedge clk_i or negedge rst_n_i) begin
        if (!rst_n_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt_o    = st_q.cnt;
    assign active_o = active;

endmodule

// File: rtl/ctl_wr_regfile.sv
module ctl_wr_regfile
    import ctl_wr_pkg::*;
#(
    parameter int       REG_COUNT = 24,
    parameter reg_val_t DFLT_BASE = 8'h10,
    parameter reg_val_t DFLT_STEP = 8'h05
) (
    input  logic                        clk_i,
    input  logic                        rst_n_i,
    input  logic                        we_i,
    input  reg_idx_t                    addr_i,
    input  reg_val_t                    data_i,
    output logic [REG_COUNT*DATA_W-1:0] regs_o
);

    reg_val_t regs_d [REG_COUNT];
    reg_val_t regs_q [REG_COUNT];

    for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
        localparam reg_val_t DFLT = reg_val_t'(DFLT_BASE + i * DFLT_STEP);
        localparam reg_idx_t IDX  = reg_idx_t'(i);

        always_comb begin
            regs_d[i] = regs_q[i];
            if (we_i && (addr_i == IDX)) begin
                regs_d[i] = data_i;
            end
        end

        always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) begin
                regs_q[i] <= DFLT;
            end else begin
                regs_q[i] <= regs_d[i];
            end
        end

        assign regs_o[i*DATA_W +: DATA_W] = regs_q[i];
    end

endmodule

// File: rtl/ctl_wr_port.sv
module ctl_wr_port
    import ctl_wr_pkg::*;
#(
    parameter int       REG_COUNT   = 24,
    parameter int       SYNC_STAGES = 2,
    parameter reg_val_t DFLT_BASE   = 8'h10,
    parameter reg_val_t DFLT_STEP   = 8'h05
) (
    input  logic                        clk_i,
    input  logic                        pdn_n_i,
    input  logic                        ps_sel_i,
    input  logic                        csn_i,
    input  logic                        sclk_i,
    input  logic                        sdi_i,
    output logic [REG_COUNT*DATA_W-1:0] regs_o
);

    localparam logic [3:0] SYNC_RST = 4'b1100;

    logic [3:0]       raw_in;
    logic [3:0]       sync_in;
    logic             commit;
    reg_idx_t         wr_addr;
    reg_val_t         wr_data;
    logic [CNT_W-1:0] frm_cnt;
    logic             port_active;

    assign raw_in = {ps_sel_i, csn_i, sclk_i, sdi_i};

    ctl_wr_sync #(
        .WIDTH   (4),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk_i   (clk_i),
        .rst_n_i (pdn_n_i),
        .async_i (raw_in),
        .sync_o  (sync_in)
    );

    ctl_wr_frame u_frame (
        .clk_i     (clk_i),
        .rst_n_i   (pdn_n_i),
        .ps_s_i    (sync_in[3]),
        .csn_s_i   (sync_in[2]),
        .sclk_s_i  (sync_in[1]),
        .sdi_s_i   (sync_in[0]),
        .commit_o  (commit),
        .wr_addr_o (wr_addr),
        .wr_data_o (wr_data),
        .cnt_o     (frm_cnt),
        .active_o  (port_active)
    );

    ctl_wr_regfile #(
        .REG_COUNT (REG_COUNT),
        .DFLT_BASE (DFLT_BASE),
        .DFLT_STEP (DFLT_STEP)
    ) u_regs (
        .clk_i   (clk_i),
        .rst_n_i (pdn_n_i),
        .we_i    (commit),
        .addr_i  (wr_addr),
        .data_i  (wr_data),
        .regs_o  (regs_o)
    );

endmodule

// File: rtl/ctl_wr_chk.sv
module ctl_wr_chk
    import ctl_wr_pkg::*;
#(
    parameter int REG_COUNT = 24
) (
    input logic                        clk_i,
    input logic                        pdn_n_i,
    input logic [REG_COUNT*DATA_W-1:0] regs_o,
    input logic                        commit,
    input reg_idx_t                    wr_addr,
    input reg_val_t                    wr_data,
    input logic [CNT_W-1:0]            frm_cnt,
    input logic                        port_active
);

    AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!pdn_n_i)
        frm_cnt <= CNT_W'(FRAME_BITS)); // R8

    AST_NO_DOUBLE_COMMIT: assert property (@(posedge clk_i) disable iff (!pdn_n_i)
        commit |=> !commit); // R8

    AST_COMMIT_NEEDS_PORT: assert property (@(posedge clk_i) disable iff (!pdn_n_i)
        commit |-> port_active); // R6

    AST_IDLE_RESTART: assert property (@(posedge clk_i) disable iff (!pdn_n_i)
        !port_active |=> frm_cnt == '0); // R7

    AST_COMMIT_AT_LAST: assert property (@(posedge clk_i) disable iff (!pdn_n_i)
        commit |=> frm_cnt == CNT_W'(FRAME_BITS)); // R5

    AST_REGS_HOLD: assert property (@(posedge clk_i) disable iff (!pdn_n_i)
        !commit |=> $stable(regs_o)); // R5

    AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!pdn_n_i)
        (commit && (int'(wr_addr) < REG_COUNT))
        |=> regs_o[int'($past(wr_addr))*DATA_W +: DATA_W] == $past(wr_data)); // R2

    AST_HIGH_INDEX_DROPPED: assert property (@(posedge clk_i) disable iff (!pdn_n_i)
        (commit && (int'(wr_addr) >= REG_COUNT)) |=> $stable(regs_o)); // R9

endmodule

bind ctl_wr_port ctl_wr_chk #(.REG_COUNT(REG_COUNT)) u_chk (
    .clk_i       (clk_i),
    .pdn_n_i     (pdn_n_i),
    .regs_o      (regs_o),
    .commit      (commit),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .frm_cnt     (frm_cnt),
    .port_active (port_active)
);

// File: tb/tb_ctl_wr_port.sv
module tb_ctl_wr_port;

    localparam int         CLK_PERIOD = 10;
    localparam int         REG_COUNT  = 24;
    localparam logic [7:0] DFLT_BASE  = 8'h10;
    localparam logic [7:0] DFLT_STEP  = 8'h05;
    localparam int         HALF_CLKS  = 4;
    localparam int         WD_CYCLES  = 180000;

    logic clk = 1'b0;
    logic pdn_n, ps_sel, csn, sclk, sdi;
    logic [REG_COUNT*8-1:0] regs;
    logic [7:0] exp_reg [REG_COUNT];
    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl_wr_port #(
        .REG_COUNT (REG_COUNT),
        .DFLT_BASE (DFLT_BASE),
        .DFLT_STEP (DFLT_STEP)
    ) dut (
        .clk_i    (clk),
        .pdn_n_i  (pdn_n),
        .ps_sel_i (ps_sel),
        .csn_i    (csn),
        .sclk_i   (sclk),
        .sdi_i    (sdi),
        .regs_o   (regs)
    );

    task automatic wait_clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_reset();
        for (int i = 0; i < REG_COUNT; i++) begin
            exp_reg[i] = 8'(DFLT_BASE + i * DFLT_STEP);
        end
    endtask

    task automatic check_file(input string req);
        int bad;
        bad = -1;
        checks++;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (bad < 0 && regs[i*8 +: 8] !== exp_reg[i]) bad = i;
        end
        if (bad >= 0) begin
            fails++;
            $display("FAIL %s reg %0d actual %02h expected %02h", req, bad,
                     regs[bad*8 +: 8], exp_reg[bad]);
        end
    endtask

    function automatic logic [15:0] mk(input logic [1:0] dev, input logic rw,
                                        input logic [4:0] idx, input logic [7:0] val);
        return {dev, rw, idx, val};
    endfunction

    task automatic send_bits(input logic [31:0] bits, input int n);
        for (int b = n - 1; b >= 0; b--) begin
            sdi = bits[b];
            wait_clks(HALF_CLKS);
            sclk = 1'b1;
            wait_clks(HALF_CLKS);
            sclk = 1'b0;
        end
    endtask

    task automatic frame(input logic [15:0] w);
        csn = 1'b0;
        wait_clks(HALF_CLKS);
        send_bits({16'h0, w}, 16);
        wait_clks(HALF_CLKS);
        csn = 1'b1;
        wait_clks(8);
    endtask

    function automatic void model_write(input logic [15:0] w);
        if (w[15:14] == 2'b01 && w[13] && int'(w[12:8]) < REG_COUNT)
            exp_reg[w[12:8]] = w[7:0];
    endfunction

    initial begin
        wait_clks(WD_CYCLES);
        fails++;
        $display("FAIL watchdog expired actual running expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] w;
        pdn_n = 1'b0; ps_sel = 1'b0; csn = 1'b1; sclk = 1'b0; sdi = 1'b0;
        model_reset();
        wait_clks(5);
        check_file("R1 reset defaults");
        pdn_n = 1'b1;
        wait_clks(10);
        check_file("R1 defaults held after release");

        // R2, R9: sweep every index and every data byte
        for (int v = 0; v < 256; v++) begin
            w = mk(2'b01, 1'b1, 5'(v % 32), 8'(v ^ 8'hA5));
            frame(w);
            model_write(w);
            check_file((v % 32) < REG_COUNT ? "R2 valid write" : "R9 high index dropped");
        end

        // R3: other device codes rejected
        for (int d = 0; d < 4; d++) begin
            w = mk(2'(d), 1'b1, 5'd7, 8'(8'h3C + d));
            frame(w);
            model_write(w);
            check_file(d == 1 ? "R2 device code 01" : "R3 device code rejected");
        end

        // R4: direction bit 0 rejected
        frame(mk(2'b01, 1'b0, 5'd2, 8'h99));
        check_file("R4 read direction ignored");

        // R5: nothing before 16th edge, write on it
        w = mk(2'b01, 1'b1, 5'd11, 8'h5A);
        csn = 1'b0;
        wait_clks(HALF_CLKS);
        send_bits({16'h0, w} >> 1, 15);
        wait_clks(10);
        check_file("R5 no change after 15 edges");
        send_bits({31'h0, w[0]}, 1);
        wait_clks(10);
        model_write(w);
        check_file("R5 commit on 16th edge");
        csn = 1'b1;
        wait_clks(8);

        // R6: serial port disabled
        ps_sel = 1'b1;
        wait_clks(4);
        frame(mk(2'b01, 1'b1, 5'd0, 8'hEE));
        check_file("R6 frame ignored in parallel mode");
        ps_sel = 1'b0;
        wait_clks(4);

        // R7: abort at every point, then fresh frame
        for (int k = 1; k < 16; k++) begin
            w = mk(2'b01, 1'b1, 5'd3, 8'(8'hC0 + k));
            csn = 1'b0;
            wait_clks(HALF_CLKS);
            send_bits({16'h0, w} >> (16 - k), k);
            wait_clks(HALF_CLKS);
            csn = 1'b1;
            wait_clks(8);
            check_file("R7 aborted frame no write");
            w = mk(2'b01, 1'b1, 5'd4, 8'(k * 9));
            frame(w);
            model_write(w);
            check_file("R7 restart after abort");
        end

        // R8: trailing edges ignored
        w = mk(2'b01, 1'b1, 5'd20, 8'h81);
        csn = 1'b0;
        wait_clks(HALF_CLKS);
        send_bits({16'h0, w}, 16);
        send_bits(32'h5, 3);
        wait_clks(HALF_CLKS);
        csn = 1'b1;
        wait_clks(8);
        model_write(w);
        check_file("R8 trailing edges ignored");

        // R1: mid-run power-down
        pdn_n = 1'b0;
        wait_clks(3);
        model_reset();
        check_file("R1 power-down restores defaults");
        pdn_n = 1'b1;
        wait_clks(6);
        w = mk(2'b01, 1'b1, 5'd23, 8'h17);
        frame(w);
        model_write(w);
        check_file("R2 write after power-down");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule